// File: doc/BRIEF.md
# Split-Register Seconds Counter RTC

This block is a real-time clock that keeps one 32-bit count of elapsed seconds. The count advances by one on every seconds tick. A parameter picks where the tick comes from. It is either an external one-pulse-per-second input, counted once per rising edge, or an internal prescaler that divides the system clock by `CLKS_PER_SEC`. No sub-second value is visible to software.

Software reaches the count through a 32-bit register bus that holds two registers. The register at byte offset 0x0 holds the upper 16 bits of the count and the register at byte offset 0x4 holds the lower 16 bits. Each register carries its half in bits 15:0. The two halves are read and written independently, and no snapshot latch joins them. A read of the upper half followed by a read of the lower half can therefore straddle an increment and return a torn value. Software must read both halves twice and retry until the two results agree. Writes behave the same way, each one replacing only its own half.

Top module: `split_seconds_rtc`

## Requirements
- R1: After a synchronous reset the count is zero, so both registers read 0x00000000.
- R2: A read at byte offset 0x0 returns count bits 31:16 in data bits 15:0. A read at offset 0x4 returns count bits 15:0 in data bits 15:0. Data bits 31:16 always read as zero.
- R3: In prescaler mode the count increments exactly once every `CLKS_PER_SEC` clock cycles. The first increment comes `CLKS_PER_SEC` cycles after reset is released. Without a tick or a write, the count holds.
- R4: In pulse mode the count increments once per rising edge of the pulse input. A pulse held high for several cycles counts once.
- R5: An increment carries from the lower half into the upper half, and the count wraps from 0xFFFFFFFF to 0x00000000.
- R6: A write to offset 0x0 replaces count bits 31:16 with write data bits 15:0 and leaves the lower half unchanged. Write data bits 31:16 are ignored.
- R7: A write to offset 0x4 replaces count bits 15:0 with write data bits 15:0 and leaves the upper half unchanged. Write data bits 31:16 are ignored.
- R8: In prescaler mode a write to either register restarts the prescaler phase. The next increment then comes exactly `CLKS_PER_SEC` cycles after the write.
- R9: When a lower-half write lands in the same cycle as a tick, the written value is stored and the whole increment is dropped. The upper half stays unchanged even where a carry would have occurred.
- R10: When an upper-half write lands in the same cycle as a tick, the lower half still increments, the upper half takes the written value, and any carry is discarded.
- R11: A write to any offset other than 0x0 and 0x4 has no effect on the count or on the prescaler phase. A read at such an offset returns zero.
- R12: Reads are not latched. Each read returns the live half at that moment, so reading the upper half before a carry and the lower half after it gives a torn result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Seconds pulse, synchronous to clk, used only in pulse mode |
| bus_addr | input | ADDR_W | Byte offset for both the read and the write |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The bench builds two copies of the block. One runs in prescaler mode with `CLKS_PER_SEC` set to 8. The other runs in pulse mode and shares the same bus. The eight-cycle second puts carries, the full wrap, write-on-tick collisions and the phase restart within a few dozen cycles, so directed sequences can place a write exactly on the tick edge. The pulse copy is driven with short and held pulses. This shows that edge counting is separate from the prescaler, and that the register rules are the same in both modes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int HALF_W  = 16;
    localparam int COUNT_W = 2 * HALF_W;
    localparam int BUS_W   = 32;

    // Byte offsets of the two halves; software decodes these positions.
    localparam int OFFS_UPPER = 0;
    localparam int OFFS_LOWER = 4;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } sec_count_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_LOWER = 2'd2
    } half_sel_e;

    typedef struct packed {
        half_sel_e         sel;
        logic [HALF_W-1:0] data;
    } half_wr_t;

    // Next count from current count, tick and a half write.
    // A lower-half write wins over the tick entirely; an upper-half write
    // keeps the incremented lower half but discards its carry.
    function automatic sec_count_t advance(input sec_count_t cur,
                                           input logic       tick,
                                           input half_wr_t   wr);
        sec_count_t bumped;
        sec_count_t nxt;
        bumped = tick ? sec_count_t'(cur + COUNT_W'(1)) : cur;
        unique case (wr.sel)
            SEL_UPPER: nxt = '{hi: wr.data, lo: bumped.lo};
            SEL_LOWER: nxt = '{hi: cur.hi,  lo: wr.data};
            default:   nxt = bumped;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rtc_tick_src.sv
module rtc_tick_src #(
    parameter bit USE_PPS      = 1'b0,
    parameter int CLKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_in,
    input  logic restart,
    output logic tick_o
);

    generate
        if (USE_PPS) begin : g_pulse
            logic pps_q;
            logic unused_restart;
            assign unused_restart = restart;

            always_ff @(posedge clk) begin
                if (rst) pps_q <= 1'b0;
                else     pps_q <= pps_in;
            end

            assign tick_o = pps_in & ~pps_q;

            // R4: a held pulse produces a single tick
            a_r4_single_edge: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end else begin : g_prescale
            localparam int PH_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
            localparam logic [PH_W-1:0] LAST_PH = PH_W'(CLKS_PER_SEC - 1);

            logic [PH_W-1:0] phase;
            logic            unused_pps;
            assign unused_pps = pps_in;

            assign tick_o = (phase == LAST_PH);

            always_ff @(posedge clk) begin
                if (rst || restart || tick_o) phase <= '0;
                else                          phase <= phase + PH_W'(1);
            end

            // R8: a register write restarts the second from phase zero
            a_r8_phase_restart: assert property (@(posedge clk) disable iff (rst)
                restart |=> (phase == '0));

            if (CLKS_PER_SEC > 1) begin : g_gap
                // R3: ticks never come back to back when a second spans cycles
                a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
                    tick_o |=> !tick_o);
            end
        end
    endgenerate

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  half_wr_t   wr,
    output sec_count_t count_o
);

    sec_count_t count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= advance(count_q, tick, wr);
    end

    assign count_o = count_q;

    // R3: no tick and no write leaves the count alone
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && wr.sel == SEL_NONE) |=> $stable(count_q));

    // R5: full wrap to zero on a tick from all ones
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && wr.sel == SEL_NONE && count_q == '1) |=> (count_q == '0));

    // R6 / R10: upper write lands in the upper half
    a_r6_upper_write: assert property (@(posedge clk) disable iff (rst)
        (wr.sel == SEL_UPPER) |=> (count_q.hi == $past(wr.data)));

    // R7 / R9: lower write lands and upper half is untouched, tick or not
    a_r9_lower_wins: assert property (@(posedge clk) disable iff (rst)
        (wr.sel == SEL_LOWER) |=> (count_q.lo == $past(wr.data)
                                   && count_q.hi == $past(count_q.hi)));

endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  sec_count_t        count,
    output logic [BUS_W-1:0]  bus_rdata,
    output half_wr_t          wr
);

    localparam logic [ADDR_W-1:0] A_UPPER = ADDR_W'(OFFS_UPPER);
    localparam logic [ADDR_W-1:0] A_LOWER = ADDR_W'(OFFS_LOWER);

    logic hit_upper;
    logic hit_lower;
    logic [BUS_W-HALF_W-1:0] unused_wdata_top;

    assign hit_upper        = (bus_addr == A_UPPER);
    assign hit_lower        = (bus_addr == A_LOWER);
    assign unused_wdata_top = bus_wdata[BUS_W-1:HALF_W];

    always_comb begin
        bus_rdata = '0;
        if (hit_upper)      bus_rdata[HALF_W-1:0] = count.hi;
        else if (hit_lower) bus_rdata[HALF_W-1:0] = count.lo;
    end

    always_comb begin
        wr.data = bus_wdata[HALF_W-1:0];
        if (bus_wr_en && hit_upper)      wr.sel = SEL_UPPER;
        else if (bus_wr_en && hit_lower) wr.sel = SEL_LOWER;
        else                             wr.sel = SEL_NONE;
    end

endmodule

// File: rtl/split_seconds_rtc.sv
module split_seconds_rtc
    import rtc_pkg::*;
#(
    parameter bit USE_PPS      = 1'b0,
    parameter int CLKS_PER_SEC = 50_000_000,
    parameter int ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    sec_count_t count;
    half_wr_t   wr;
    logic       tick;
    logic       restart;

    assign restart = (wr.sel != SEL_NONE);

    rtc_reg_port #(.ADDR_W(ADDR_W)) u_port (
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .count     (count),
        .bus_rdata (bus_rdata),
        .wr        (wr)
    );

    rtc_tick_src #(.USE_PPS(USE_PPS), .CLKS_PER_SEC(CLKS_PER_SEC)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .pps_in  (pps_in),
        .restart (restart),
        .tick_o  (tick)
    );

    rtc_sec_counter u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr      (wr),
        .count_o (count)
    );

endmodule

// File: tb/test_split_seconds_rtc.sv
module test_split_seconds_rtc;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps = 1'b0;
    logic [3:0]  baddr = 4'h0;
    logic        bwr = 1'b0;
    logic [31:0] bwd = '0;
    logic [31:0] rd_pre;
    logic [31:0] rd_pps;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    split_seconds_rtc #(.USE_PPS(1'b0), .CLKS_PER_SEC(N), .ADDR_W(4)) i_split_seconds_rtc (
        .clk(clk), .rst(rst), .pps_in(pps), .bus_addr(baddr),
        .bus_wr_en(bwr), .bus_wdata(bwd), .bus_rdata(rd_pre));

    split_seconds_rtc #(.USE_PPS(1'b1), .CLKS_PER_SEC(N), .ADDR_W(4)) i_split_seconds_rtc_pps (
        .clk(clk), .rst(rst), .pps_in(pps), .bus_addr(baddr),
        .bus_wr_en(bwr), .bus_wdata(bwd), .bus_rdata(rd_pps));

    // Reference model built from the requirements
    logic [31:0] m_pre, m_pps;
    int          m_ph;
    logic        m_ppsq;
    bit          t_pre, t_pps;

    function automatic logic [31:0] ref_next(input logic [31:0] c, input bit tick,
                                             input logic wr, input logic [3:0] a,
                                             input logic [31:0] d);
        logic [31:0] inc;
        inc = tick ? c + 32'd1 : c;
        if (wr && a == 4'h0) return {d[15:0], inc[15:0]};
        if (wr && a == 4'h4) return {c[31:16], d[15:0]};
        return inc;
    endfunction

    function automatic logic [31:0] ref_read(input logic [31:0] c, input logic [3:0] a);
        if (a == 4'h0) return {16'h0, c[31:16]};
        if (a == 4'h4) return {16'h0, c[15:0]};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre <= '0; m_pps <= '0; m_ph <= 0; m_ppsq <= 1'b0;
        end else begin
            t_pre = (m_ph == N - 1);
            t_pps = pps && !m_ppsq;
            m_pre <= ref_next(m_pre, t_pre, bwr, baddr, bwd);
            m_pps <= ref_next(m_pps, t_pps, bwr, baddr, bwd);
            m_ph  <= ((bwr && (baddr == 4'h0 || baddr == 4'h4)) || t_pre) ? 0 : m_ph + 1;
            m_ppsq <= pps;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample 1 ns later
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bwr = w; baddr = a; bwd = d; pps = p;
        #1;
        check("R2 prescaler read vs model", rd_pre, ref_read(m_pre, a));
        check("R2 pulse read vs model", rd_pps, ref_read(m_pps, a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'h4, 32'h0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h0051_7ec5));
        repeat (3) @(negedge clk);
        rst = 1'b0; baddr = 4'h4;
        #1;
        check("R1 lower after reset", rd_pre, 32'h0);

        // R3: first increment after N cycles from reset release
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R1 upper after reset", rd_pre, 32'h0);
        idle(5);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R3 no increment before N cycles", rd_pre, 32'h0);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R3 first increment", rd_pre, 32'h1);

        // R4: held pulse counts once
        cyc(1'b0, 4'h4, 32'h0, 1'b1);
        cyc(1'b0, 4'h4, 32'h0, 1'b1);
        cyc(1'b0, 4'h4, 32'h0, 1'b1);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R4 held pulse counted once", rd_pps, 32'h1);
        cyc(1'b0, 4'h4, 32'h0, 1'b1);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R4 second pulse", rd_pps, 32'h2);

        // R6 / R7 / R11 / R8
        cyc(1'b1, 4'h4, 32'h0000_2222, 1'b0);
        cyc(1'b1, 4'h0, 32'hABCD_1357, 1'b0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R6 upper written, top bits ignored", rd_pre, 32'h0000_1357);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R6 lower unchanged", rd_pre, 32'h0000_2222);
        cyc(1'b1, 4'h4, 32'hFFFF_9999, 1'b0);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R7 lower written, top bits ignored", rd_pre, 32'h0000_9999);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R7 upper unchanged", rd_pre, 32'h0000_1357);
        cyc(1'b1, 4'h8, 32'hDEAD_BEEF, 1'b0);
        cyc(1'b0, 4'h8, 32'h0, 1'b0);
        check("R11 unmapped read is zero", rd_pre, 32'h0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R11 unmapped write no effect upper", rd_pre, 32'h0000_1357);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R11 unmapped write no effect lower", rd_pre, 32'h0000_9999);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R8 no increment before N cycles after write", rd_pre, 32'h0000_9999);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R8 increment N cycles after write", rd_pre, 32'h0000_999A);

        // R9 then R5 carry
        cyc(1'b1, 4'h0, 32'h0000_0005, 1'b0);
        cyc(1'b1, 4'h4, 32'h0000_1234, 1'b0);
        idle(7);
        cyc(1'b1, 4'h4, 32'h0000_FFFF, 1'b0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R9 upper kept on lower write with tick", rd_pre, 32'h0000_0005);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R9 lower write wins over tick", rd_pre, 32'h0000_FFFF);
        idle(6);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R5 carry into upper", rd_pre, 32'h0000_0006);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R5 lower rolls to zero", rd_pre, 32'h0);

        // R5 full wrap
        cyc(1'b1, 4'h0, 32'h0000_FFFF, 1'b0);
        cyc(1'b1, 4'h4, 32'h0000_FFFF, 1'b0);
        idle(8);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R5 wrap upper", rd_pre, 32'h0);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R5 wrap lower", rd_pre, 32'h0);

        // R12 torn read across a carry
        cyc(1'b1, 4'h0, 32'h0000_0001, 1'b0);
        cyc(1'b1, 4'h4, 32'h0000_FFFF, 1'b0);
        idle(6);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R12 upper read before carry", rd_pre, 32'h0000_0001);
        idle(1);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R12 lower read after carry (torn)", rd_pre, 32'h0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R12 live upper after carry", rd_pre, 32'h0000_0002);

        // R10 upper write on the tick
        cyc(1'b1, 4'h0, 32'h0000_0007, 1'b0);
        cyc(1'b1, 4'h4, 32'h0000_FFFF, 1'b0);
        idle(7);
        cyc(1'b1, 4'h0, 32'h0000_0020, 1'b0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R10 upper takes write, carry dropped", rd_pre, 32'h0000_0020);
        cyc(1'b0, 4'h4, 32'h0, 1'b0);
        check("R10 lower still increments", rd_pre, 32'h0);

        // R2 upper data bits read zero
        cyc(1'b1, 4'h0, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0);
        check("R2 upper data bits zero", rd_pre, 32'h0000_FFFF);

        // Random mix checked against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] a;
            case ($urandom_range(0, 5))
                0, 1, 2: a = 4'h4;
                3, 4:    a = 4'h0;
                default: a = ($urandom_range(0, 1) != 0) ? 4'h8 : 4'hC;
            endcase
            cyc(($urandom_range(0, 5) == 0), a, $urandom(),
                ($urandom_range(0, 9) == 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule